// File: doc/BRIEF.md
# Platform status and control register block

This block is a small bank of 32-bit registers that sits in a 4 KiB window on a simple bus slave port. Software reads it to learn the board build identity, the memory and link health, the timer input clock rate, the installed memory size and which optional units were built in. Software also writes one control register to ask for a system-wide soft reset.

Most read values are not stored. They are put together at read time from configuration inputs placed in fixed bit fields. The block holds only three registers of state: the read data, a one-cycle reset request and a one-cycle unimplemented-access flag. Writes to registers that are only reported are accepted and dropped. The only write with an effect is the reset request bit.

Each access presents an address, a read or write strobe, an access size in bytes and write data. The results appear one clock later.

Top module: `plat_regs`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `bus_rdata`, `sys_rst_req` and `unimpl_pulse` are all zero.
- R2: Only the low 16 address bits are decoded. A read at 0xABCD0014 returns the same value as a read at 0x0014. An offset that does not match a register exactly, such as 0x0015, is treated as undecoded.
- R3: A word read of memory status (0x14) returns 0x00000005. This means locked (bit 0) and calibrated (bit 2).
- R4: A word read of the clock divider register (0x30) returns 8'h01 in bits 31:24, 8'h01 in bits 23:16, `timer_mhz` in bits 15:8 and 8'h01 in bits 7:0.
- R5: A word read of build configuration (0x34) returns 0x0000000E. Bit 0 is the coherence unit flag and reads 0. Bits 1, 2 and 3 are the enable flags of links 0, 1 and 2 and read 1.
- R6: A word read of memory configuration (0x38) returns `mem_gib` in bits 3:0 and 0xFFF in bits 15:4. Bits 31:16 are zero.
- R7: A word read of link status (0x18) returns `link_lock[0]` at bit 0, `link_lock[1]` at bit 8 and `link_lock[2]` at bit 16. All other bits are zero.
- R8: Build ID (0x00) and wrapper changelist (0x08) read as their parameter values, which are zero by default. Word writes to 0x00, 0x08, 0x14 and 0x18 raise no flag and leave their read-back values unchanged.
- R9: A word write to soft-reset control (0x10) with bit 4 set drives `sys_rst_req` high for exactly the next cycle. The other data bits do not matter. The same write with bit 4 clear gives no request.
- R10: An access whose `bus_size` (in bytes) is not 4 is unsupported. Such a read returns zero and such a write has no effect; either pulses `unimpl_pulse` in the next cycle.
- R11: A word read of any offset other than 0x00, 0x08, 0x14, 0x18, 0x30, 0x34 or 0x38 returns zero and pulses `unimpl_pulse`. The offsets this covers include 0x0c, 0x10, 0x1c, 0x3c, 0x40 and 0x44. A word write to any offset other than 0x00, 0x08, 0x10, 0x14 or 0x18 pulses `unimpl_pulse`.
- R12: `bus_rdata` updates only in the cycle after a read and holds its value between reads. A read and a write in the same cycle are both carried out. `unimpl_pulse` is high for one cycle after each offending access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address; low 16 bits decoded |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 3 | Access size in bytes (4 = word) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| timer_mhz | input | 8 | Timer input clock in MHz |
| mem_gib | input | 4 | Installed memory in GiB |
| link_lock | input | 3 | Per-link lock flags |
| sys_rst_req | output | 1 | One-cycle system reset request |
| unimpl_pulse | output | 1 | One-cycle unimplemented-access flag |

## Verification
A reset request and an unimplemented-access flag can fall in the same cycle. Soft-reset control accepts writes but cannot be read, so a read and a write strobed together at 0x10 with bit 4 set must raise both `sys_rst_req` and `unimpl_pulse` in the following cycle, with `bus_rdata` at zero. The bench provokes this with both strobes in one cycle. It also repeats the write with a half-word size to show that the flag alone appears and the reset stays low.

// File: rtl/plat_regs_pkg.sv
package plat_regs_pkg;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_BUILD,
      SEL_CHGL,
      SEL_CLKST,
      SEL_SRST,
      SEL_MEMST,
      SEL_LINKST,
      SEL_FLASH,
      SEL_CLKDIV,
      SEL_BCFG,
      SEL_MEMCFG,
      SEL_LADDR
   } reg_sel_e;

   localparam int unsigned OFF_BUILD  = 'h00;
   localparam int unsigned OFF_CHGL   = 'h08;
   localparam int unsigned OFF_CLKST  = 'h0c;
   localparam int unsigned OFF_SRST   = 'h10;
   localparam int unsigned OFF_MEMST  = 'h14;
   localparam int unsigned OFF_LINKST = 'h18;
   localparam int unsigned OFF_FLASH  = 'h1c;
   localparam int unsigned OFF_CLKDIV = 'h30;
   localparam int unsigned OFF_BCFG   = 'h34;
   localparam int unsigned OFF_MEMCFG = 'h38;
   localparam int unsigned OFF_LADDR0 = 'h3c;

   localparam int unsigned MEMST_LOCK_BIT = 0;
   localparam int unsigned MEMST_CAL_BIT  = 2;

endpackage

// File: rtl/plat_regs_decode.sv
module plat_regs_decode
   import plat_regs_pkg::*;
#(
   parameter int unsigned DEC_W   = 16,
   parameter int unsigned N_LINKS = 3
) (
   input  logic [DEC_W-1:0] off,
   output reg_sel_e         sel
);

   localparam int unsigned LADDR_STEP = 4;

   generate
      if (DEC_W < 8) begin : g_bad_dec
         $error("plat_regs_decode: DEC_W too small for the register map");
      end
   endgenerate

   logic [N_LINKS-1:0] laddr_hit;

   generate
      for (genvar i = 0; i < N_LINKS; i++) begin : g_laddr
         assign laddr_hit[i] = (off == DEC_W'(OFF_LADDR0 + LADDR_STEP * i));
      end
   endgenerate

   always_comb begin
      sel = SEL_NONE;
      if      (off == DEC_W'(OFF_BUILD))  sel = SEL_BUILD;
      else if (off == DEC_W'(OFF_CHGL))   sel = SEL_CHGL;
      else if (off == DEC_W'(OFF_CLKST))  sel = SEL_CLKST;
      else if (off == DEC_W'(OFF_SRST))   sel = SEL_SRST;
      else if (off == DEC_W'(OFF_MEMST))  sel = SEL_MEMST;
      else if (off == DEC_W'(OFF_LINKST)) sel = SEL_LINKST;
      else if (off == DEC_W'(OFF_FLASH))  sel = SEL_FLASH;
      else if (off == DEC_W'(OFF_CLKDIV)) sel = SEL_CLKDIV;
      else if (off == DEC_W'(OFF_BCFG))   sel = SEL_BCFG;
      else if (off == DEC_W'(OFF_MEMCFG)) sel = SEL_MEMCFG;
      else if (|laddr_hit)                sel = SEL_LADDR;
   end

endmodule

// File: rtl/plat_regs_rdval.sv
module plat_regs_rdval
   import plat_regs_pkg::*;
#(
   parameter int unsigned            DATA_W     = 32,
   parameter int unsigned            N_LINKS    = 3,
   parameter int unsigned            LANE_W     = 8,
   parameter int unsigned            MHZ_W      = 8,
   parameter int unsigned            GIB_W      = 4,
   parameter logic [DATA_W-1:0]      BUILD_ID   = '0,
   parameter logic [DATA_W-1:0]      CHANGELIST = '0,
   parameter logic                   COHER_EN   = 1'b0,
   parameter logic [N_LINKS-1:0]     LINK_EN    = '1
) (
   input  reg_sel_e            sel,
   input  logic [MHZ_W-1:0]    timer_mhz,
   input  logic [GIB_W-1:0]    mem_gib,
   input  logic [N_LINKS-1:0]  link_lock,
   output logic [DATA_W-1:0]   val,
   output logic                readable
);

   localparam int unsigned N_LANES = DATA_W / LANE_W;
   localparam int unsigned MEMF_W  = 16;
   localparam int unsigned SPEED_W = MEMF_W - GIB_W;
   localparam int unsigned BCFG_W  = N_LINKS + 1;

   generate
      if (N_LINKS > N_LANES) begin : g_bad_links
         $error("plat_regs_rdval: more links than status lanes");
      end
      if (MHZ_W != LANE_W) begin : g_bad_mhz
         $error("plat_regs_rdval: frequency field must fill one lane");
      end
      if (GIB_W >= MEMF_W) begin : g_bad_gib
         $error("plat_regs_rdval: size field leaves no room for speed");
      end
   endgenerate

   logic [DATA_W-1:0] link_word;
   logic [DATA_W-1:0] clkdiv_word;
   logic [DATA_W-1:0] bcfg_word;
   logic [DATA_W-1:0] memcfg_word;
   logic [DATA_W-1:0] memst_word;

   generate
      for (genvar i = 0; i < N_LANES; i++) begin : g_lane
         if (i < N_LINKS) begin : g_used
            assign link_word[i*LANE_W +: LANE_W] = {{(LANE_W-1){1'b0}}, link_lock[i]};
         end else begin : g_idle
            assign link_word[i*LANE_W +: LANE_W] = '0;
         end
      end
   endgenerate

   assign clkdiv_word = DATA_W'({LANE_W'(1), LANE_W'(1), timer_mhz, LANE_W'(1)});
   assign bcfg_word   = DATA_W'({LINK_EN, COHER_EN});
   assign memcfg_word = DATA_W'({{SPEED_W{1'b1}}, mem_gib});
   assign memst_word  = DATA_W'((1 << MEMST_LOCK_BIT) | (1 << MEMST_CAL_BIT));

   always_comb begin
      val      = '0;
      readable = 1'b1;
      case (sel)
         SEL_BUILD:  val = BUILD_ID;
         SEL_CHGL:   val = CHANGELIST;
         SEL_MEMST:  val = memst_word;
         SEL_LINKST: val = link_word;
         SEL_CLKDIV: val = clkdiv_word;
         SEL_BCFG:   val = bcfg_word;
         SEL_MEMCFG: val = memcfg_word;
         default:    readable = 1'b0;
      endcase
   end

   logic unused_w;
   assign unused_w = ^BCFG_W;

endmodule

// File: rtl/plat_regs_wrctl.sv
module plat_regs_wrctl
   import plat_regs_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned RST_BIT = 4
) (
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] wdata,
   output logic              rst_hit,
   output logic              wr_bad
);

   generate
      if (RST_BIT >= DATA_W) begin : g_bad_bit
         $error("plat_regs_wrctl: reset bit outside data word");
      end
   endgenerate

   always_comb begin
      rst_hit = 1'b0;
      wr_bad  = 1'b0;
      case (sel)
         SEL_BUILD, SEL_CHGL, SEL_MEMST, SEL_LINKST: ;
         SEL_SRST: rst_hit = wdata[RST_BIT];
         default:  wr_bad  = 1'b1;
      endcase
   end

endmodule

// File: rtl/plat_regs.sv
module plat_regs
   import plat_regs_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DEC_W      = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned SIZE_W     = 3,
   parameter int unsigned N_LINKS    = 3,
   parameter int unsigned LANE_W     = 8,
   parameter int unsigned MHZ_W      = 8,
   parameter int unsigned GIB_W      = 4,
   parameter int unsigned RST_BIT    = 4,
   parameter logic [31:0] BUILD_ID   = 32'h0,
   parameter logic [31:0] CHANGELIST = 32'h0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_rd,
   input  logic               bus_wr,
   input  logic [SIZE_W-1:0]  bus_size,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [MHZ_W-1:0]   timer_mhz,
   input  logic [GIB_W-1:0]   mem_gib,
   input  logic [N_LINKS-1:0] link_lock,
   output logic               sys_rst_req,
   output logic               unimpl_pulse
);

   localparam int unsigned WORD_BYTES = DATA_W / 8;

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("plat_regs: register width must be 32");
      end
      if (DEC_W > ADDR_W) begin : g_bad_addr
         $error("plat_regs: decode width exceeds address width");
      end
      if (WORD_BYTES >= (1 << SIZE_W)) begin : g_bad_size
         $error("plat_regs: size field cannot encode a word");
      end
   endgenerate

   reg_sel_e          sel;
   logic [DATA_W-1:0] rd_val;
   logic              readable;
   logic              rst_hit;
   logic              wr_bad;
   logic              is_word;

   assign is_word = (bus_size == SIZE_W'(WORD_BYTES));

   plat_regs_decode #(.DEC_W(DEC_W), .N_LINKS(N_LINKS)) u_dec (
      .off (bus_addr[DEC_W-1:0]),
      .sel (sel)
   );

   plat_regs_rdval #(
      .DATA_W     (DATA_W),
      .N_LINKS    (N_LINKS),
      .LANE_W     (LANE_W),
      .MHZ_W      (MHZ_W),
      .GIB_W      (GIB_W),
      .BUILD_ID   (BUILD_ID[DATA_W-1:0]),
      .CHANGELIST (CHANGELIST[DATA_W-1:0])
   ) u_rd (
      .sel       (sel),
      .timer_mhz (timer_mhz),
      .mem_gib   (mem_gib),
      .link_lock (link_lock),
      .val       (rd_val),
      .readable  (readable)
   );

   plat_regs_wrctl #(.DATA_W(DATA_W), .RST_BIT(RST_BIT)) u_wr (
      .sel     (sel),
      .wdata   (bus_wdata),
      .rst_hit (rst_hit),
      .wr_bad  (wr_bad)
   );

   logic rd_unimpl;
   logic wr_unimpl;

   assign rd_unimpl = bus_rd && !(is_word && readable);
   assign wr_unimpl = bus_wr && !(is_word && !wr_bad);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata    <= '0;
         sys_rst_req  <= 1'b0;
         unimpl_pulse <= 1'b0;
      end else begin
         if (bus_rd) begin
            bus_rdata <= (is_word && readable) ? rd_val : '0;
         end
         sys_rst_req  <= bus_wr && is_word && rst_hit;
         unimpl_pulse <= rd_unimpl || wr_unimpl;
      end
   end

   // R9
   rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> $past(bus_wr && bus_size == SIZE_W'(WORD_BYTES) &&
                            bus_addr[DEC_W-1:0] == DEC_W'(OFF_SRST) && bus_wdata[RST_BIT]));

   // R10
   size_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_size != SIZE_W'(WORD_BYTES)) && (bus_rd || bus_wr)
         |=> unimpl_pulse && !sys_rst_req);

   // R10
   size_rdzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_size != SIZE_W'(WORD_BYTES)) && bus_rd |=> bus_rdata == '0);

   // R3
   memst_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && is_word && bus_addr[DEC_W-1:0] == DEC_W'(OFF_MEMST)
         |=> bus_rdata == DATA_W'(5));

   // R12
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/plat_regs_test.sv
module plat_regs_test;

   localparam int CLK_PERIOD = 10;
   localparam int N_VEC      = 17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_size = 3'd4;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  timer_mhz = 8'd50;
   logic [3:0]  mem_gib = 4'd2;
   logic [2:0]  link_lock = 3'b101;
   logic        sys_rst_req;
   logic        unimpl_pulse;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   plat_regs uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_rd       (bus_rd),
      .bus_wr       (bus_wr),
      .bus_size     (bus_size),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .timer_mhz    (timer_mhz),
      .mem_gib      (mem_gib),
      .link_lock    (link_lock),
      .sys_rst_req  (sys_rst_req),
      .unimpl_pulse (unimpl_pulse)
   );

   // {req, addr, size, expected data, expected flag}
   typedef struct packed {
      logic [7:0]  req;
      logic [31:0] addr;
      logic [2:0]  size;
      logic [31:0] exp;
      logic        flag;
   } vec_t;

   localparam vec_t VECS [N_VEC] = '{
      '{8'd8,  32'h0000_0000, 3'd4, 32'h0000_0000, 1'b0},  // R8 build ID
      '{8'd8,  32'h0000_0008, 3'd4, 32'h0000_0000, 1'b0},  // R8 changelist
      '{8'd11, 32'h0000_000c, 3'd4, 32'h0000_0000, 1'b1},  // R11
      '{8'd11, 32'h0000_0010, 3'd4, 32'h0000_0000, 1'b1},  // R11
      '{8'd3,  32'h0000_0014, 3'd4, 32'h0000_0005, 1'b0},  // R3
      '{8'd7,  32'h0000_0018, 3'd4, 32'h0001_0001, 1'b0},  // R7
      '{8'd11, 32'h0000_001c, 3'd4, 32'h0000_0000, 1'b1},  // R11
      '{8'd4,  32'h0000_0030, 3'd4, 32'h0101_3201, 1'b0},  // R4
      '{8'd5,  32'h0000_0034, 3'd4, 32'h0000_000e, 1'b0},  // R5
      '{8'd6,  32'h0000_0038, 3'd4, 32'h0000_fff2, 1'b0},  // R6
      '{8'd11, 32'h0000_003c, 3'd4, 32'h0000_0000, 1'b1},  // R11
      '{8'd11, 32'h0000_0040, 3'd4, 32'h0000_0000, 1'b1},  // R11
      '{8'd11, 32'h0000_0044, 3'd4, 32'h0000_0000, 1'b1},  // R11
      '{8'd11, 32'h0000_0004, 3'd4, 32'h0000_0000, 1'b1},  // R11
      '{8'd2,  32'habcd_0014, 3'd4, 32'h0000_0005, 1'b0},  // R2
      '{8'd2,  32'h0000_0015, 3'd4, 32'h0000_0000, 1'b1},  // R2 unaligned
      '{8'd10, 32'h0000_0014, 3'd2, 32'h0000_0000, 1'b1}   // R10
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   logic [31:0] o_data;
   logic        o_rst;
   logic        o_flag;

   // drive at negedge, outputs registered at the next posedge, sampled at following negedge
   task automatic access(input logic rd, input logic wr, input logic [31:0] addr,
                         input logic [2:0] size, input logic [31:0] wd);
      bus_rd    = rd;
      bus_wr    = wr;
      bus_addr  = addr;
      bus_size  = size;
      bus_wdata = wd;
      @(negedge clk);
      o_data = bus_rdata;
      o_rst  = sys_rst_req;
      o_flag = unimpl_pulse;
      bus_rd = 1'b0;
      bus_wr = 1'b0;
      bus_size = 3'd4;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      check("R1 rdata", bus_rdata, 0);
      check("R1 rst_req", {31'd0, sys_rst_req}, 0);
      check("R1 flag", {31'd0, unimpl_pulse}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {bus_rdata[29:0], sys_rst_req, unimpl_pulse}, 0);

      for (int i = 0; i < N_VEC; i++) begin
         access(1'b1, 1'b0, VECS[i].addr, VECS[i].size, 32'h0);
         check($sformatf("R%0d data @%08h", VECS[i].req, VECS[i].addr), o_data, VECS[i].exp);
         check($sformatf("R%0d flag @%08h", VECS[i].req, VECS[i].addr), {31'd0, o_flag},
               {31'd0, VECS[i].flag});
      end

      // R9 reset request on bit 4, one-cycle pulse
      access(1'b0, 1'b1, 32'h10, 3'd4, 32'h0000_0010);
      check("R9 pulse", {31'd0, o_rst}, 1);
      check("R9 flag", {31'd0, o_flag}, 0);
      @(negedge clk);
      check("R9 single cycle", {31'd0, sys_rst_req}, 0);
      access(1'b0, 1'b1, 32'h10, 3'd4, 32'hffff_ffef);
      check("R9 bit4 clear", {31'd0, o_rst}, 0);
      access(1'b0, 1'b1, 32'h1234_0010, 3'd4, 32'h0000_0010);
      check("R9 upper addr ignored", {31'd0, o_rst}, 1);

      // R10 non-word write: no reset, flag
      access(1'b0, 1'b1, 32'h10, 3'd2, 32'h0000_0010);
      check("R10 no reset", {31'd0, o_rst}, 0);
      check("R10 flag", {31'd0, o_flag}, 1);

      // R8 silent writes
      access(1'b0, 1'b1, 32'h14, 3'd4, 32'hdead_beef);
      check("R8 memst write flag", {31'd0, o_flag}, 0);
      access(1'b0, 1'b1, 32'h00, 3'd4, 32'h1234_5678);
      check("R8 build write flag", {31'd0, o_flag}, 0);
      access(1'b1, 1'b0, 32'h14, 3'd4, 0);
      check("R8 memst unchanged", o_data, 32'h5);
      access(1'b1, 1'b0, 32'h00, 3'd4, 0);
      check("R8 build unchanged", o_data, 32'h0);

      // R11 write to undecoded / non-writable
      access(1'b0, 1'b1, 32'h34, 3'd4, 32'h0);
      check("R11 write bcfg flag", {31'd0, o_flag}, 1);
      access(1'b0, 1'b1, 32'h80, 3'd4, 32'h0);
      check("R11 write undecoded flag", {31'd0, o_flag}, 1);

      // R12 hold between reads
      access(1'b1, 1'b0, 32'h34, 3'd4, 0);
      @(negedge clk);
      @(negedge clk);
      check("R12 rdata held", bus_rdata, 32'he);
      check("R12 flag one cycle", {31'd0, unimpl_pulse}, 0);

      // R12 read and write together at soft-reset control
      access(1'b1, 1'b1, 32'h10, 3'd4, 32'h0000_0010);
      check("R12 both rst", {31'd0, o_rst}, 1);
      check("R12 both flag", {31'd0, o_flag}, 1);
      check("R12 both data", o_data, 0);

      // R4, R6, R7 with new configuration inputs
      timer_mhz = 8'd100;
      mem_gib   = 4'd1;
      link_lock = 3'b010;
      access(1'b1, 1'b0, 32'h30, 3'd4, 0);
      check("R4 mhz 100", o_data, 32'h0101_6401);
      access(1'b1, 1'b0, 32'h38, 3'd4, 0);
      check("R6 1 GiB", o_data, 32'h0000_fff1);
      access(1'b1, 1'b0, 32'h18, 3'd4, 0);
      check("R7 link1", o_data, 32'h0000_0100);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule